// File: doc/BRIEF.md
# Sampling converter serial port and power sequencer

This block is the digital control side of a 12-bit sampling converter, written as a synthesizable behavioural model. A rising edge on the conversion-start input begins a conversion, which lasts a parameterized number of system clock cycles. A parallel input port stands in for the successive-approximation result. When the conversion finishes, the result is captured into an output shift register. The level of the conversion-start input at that moment selects what happens next. If the input is low, the block stays powered and the first result bit is presented at once. If the input is high, the block drops into nap or sleep, as chosen by the sleep flag received in the previous serial frame.

While the conversion-start input is low, the serial port is enabled. The serial clock, the serial data input and the conversion-start input are all synchronized into the system clock and edge-detected. Falling serial-clock edges step the result out, most significant bit first. The first six rising serial-clock edges collect a configuration word that governs the next conversion and the next power decision. Leaving sleep takes a parameterized wake-up period before the block counts as powered again. Status outputs report the power state, the latched configuration and the acquisition phase.

Top module: `adc_port_seq`

## Requirements
- R1: After reset the block is in the following state: power state IDLE (0), configuration 6'b100000 (single-ended, channel 0, bipolar, sleep flag 0), `sdo_oe_o` low, `sdo_o` low and `acq_o` low.
- R2: A rising edge on `convst_i` seen in IDLE starts a conversion. The power state is then CONV (1) for exactly CONV_CYC cycles. Any further `convst_i` edges during CONV are ignored and do not restart or extend the conversion.
- R3: If `convst_i` is high when a conversion ends, the power state becomes NAP (2) when the latched sleep flag (configuration bit 0) is 0, and SLEEP (3) when it is 1.
- R4: If `convst_i` is low when a conversion ends, the power state returns to IDLE, and `sdo_o` shows bit 11 of the captured `sar_data_i` at once.
- R5: `sdo_oe_o` is low while the synchronized `convst_i` is high and high while it is low. The synchronizer adds a two-cycle delay. `sdo_o` reads 0 whenever `sdo_oe_o` is low.
- R6: `sdo_o` presents result bit 11 first. Each synchronized falling edge of `sck_i` advances it to the next lower bit, down to bit 0. After bit 0, `sdo_o` holds 0. `sck_i` edges seen while `convst_i` is high have no effect.
- R7: `sdi_i` is sampled on the first six rising edges of `sck_i` after a conversion, first bit into `cfg_o[5]`. The fields are:
  - `cfg_o[5]`: 1 = single-ended against the common input.
  - `cfg_o[4]`: odd/sign select.
  - `cfg_o[3:2]`: channel pair address.
  - `cfg_o[1]`: 1 = unipolar.
  - `cfg_o[0]`: sleep flag.
  
  `cfg_o` changes only on the sixth edge. Later rising edges leave it unchanged until the next conversion starts.
- R8: `acq_o` rises when the sixth configuration bit is latched and clears when a conversion starts.
- R9: From NAP, a low `convst_i` returns the power state to IDLE. From SLEEP, a low `convst_i` moves the power state to WAKE (4) for exactly WAKE_CYC cycles, then to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| convst_i | input | 1 | Conversion start and output enable control |
| sck_i | input | 1 | Serial clock, asynchronous to clk_i |
| sdi_i | input | 1 | Serial configuration data |
| sar_data_i | input | RES_W | Parallel result standing in for the converter |
| sdo_o | output | 1 | Serial result data |
| sdo_oe_o | output | 1 | Output enable for sdo_o (tri-state control) |
| pwr_state_o | output | 3 | Power state: 0 idle, 1 conv, 2 nap, 3 sleep, 4 wake |
| cfg_o | output | 6 | Latched configuration word |
| acq_o | output | 1 | Acquisition phase flag |

## Verification
Each input change passes through two synchronizer stages before any edge detect. A registered output therefore moves on the third rising clock edge after the input change. The bench drives inputs on falling clock edges and samples state changes at that exact edge count. It checks that CONV still holds after CONV_CYC+2 edges and has ended after CONV_CYC+3. The wake window is checked the same way, using WAKE_CYC. Serial clock phases last four system cycles, so every result bit and configuration update has settled before the bench samples it, one cycle before the next phase.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    PS_IDLE  = 3'd0,
    PS_CONV  = 3'd1,
    PS_NAP   = 3'd2,
    PS_SLEEP = 3'd3,
    PS_WAKE  = 3'd4
  } pwr_state_e;

  localparam int CFG_W = 6;
  localparam logic [CFG_W-1:0] CFG_RESET = 6'b100000;
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYC = 16,
  parameter int WAKE_CYC = 10000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       conv_lvl_i,
  input  logic       conv_rise_i,
  input  logic       slp_i,
  output pwr_state_e state_o,
  output logic       start_o,
  output logic       done_o
);
  localparam int CNT_MAX = (CONV_CYC > WAKE_CYC) ? CONV_CYC : WAKE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  pwr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign start_o = (state_q == PS_IDLE) && conv_rise_i;
  assign done_o  = (state_q == PS_CONV) && (cnt_q == '0);
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PS_IDLE: if (conv_rise_i) begin
          state_q <= PS_CONV;
          cnt_q   <= CNT_W'(CONV_CYC - 1);
        end
        PS_CONV: begin
          if (cnt_q == '0) begin
            if (conv_lvl_i) state_q <= slp_i ? PS_SLEEP : PS_NAP;
            else            state_q <= PS_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PS_NAP: if (!conv_lvl_i) state_q <= PS_IDLE;
        PS_SLEEP: if (!conv_lvl_i) begin
          state_q <= PS_WAKE;
          cnt_q   <= CNT_W'(WAKE_CYC - 1);
        end
        PS_WAKE: begin
          if (cnt_q == '0) state_q <= PS_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sck_rise_i,
  input  logic             sck_fall_i,
  input  logic             sdi_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic [RES_W-1:0] result_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             acq_o,
  output logic             sdo_bit_o
);
  localparam int RC_W = $clog2(CFG_W + 1);

  logic [RES_W-1:0] out_sr_q;
  logic [CFG_W-2:0] in_sr_q;
  logic [RC_W-1:0]  rcnt_q;
  logic [CFG_W-1:0] cfg_q;
  logic             acq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_sr_q <= '0;
      rcnt_q  <= '0;
      cfg_q   <= CFG_RESET;
      acq_q   <= 1'b0;
    end else if (start_i) begin
      rcnt_q <= '0;
      acq_q  <= 1'b0;
    end else if (en_i && sck_rise_i && (rcnt_q < RC_W'(CFG_W))) begin
      rcnt_q <= rcnt_q + 1'b1;
      if (rcnt_q == RC_W'(CFG_W - 1)) begin
        cfg_q <= {in_sr_q, sdi_i};
        acq_q <= 1'b1;
      end else begin
        in_sr_q <= {in_sr_q[CFG_W-3:0], sdi_i};
      end
    end
  end

  // result load wins over a coincident shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                out_sr_q <= '0;
    else if (done_i)            out_sr_q <= result_i;
    else if (en_i && sck_fall_i) out_sr_q <= {out_sr_q[RES_W-2:0], 1'b0};
  end

  assign cfg_o     = cfg_q;
  assign acq_o     = acq_q;
  assign sdo_bit_o = out_sr_q[RES_W-1];
endmodule

// File: rtl/adc_port_seq.sv
module adc_port_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W    = 12,
  parameter int CONV_CYC = 16,
  parameter int WAKE_CYC = 10000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             convst_i,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic [RES_W-1:0] sar_data_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [2:0]       pwr_state_o,
  output logic [5:0]       cfg_o,
  output logic             acq_o
);
  logic       conv_s, sck_s, sdi_s;
  logic       conv_prev_q, sck_prev_q;
  logic       conv_rise, sck_rise, sck_fall;
  logic       start, done, sdo_bit, port_en;
  pwr_state_e state;

  // convst resets high so the output starts disabled
  adc_sync #(.W(1), .RST_VAL(1'b1)) i_sync_conv (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(convst_i), .q_o(conv_s)
  );

  adc_sync #(.W(2), .RST_VAL(2'b00)) i_sync_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({sck_i, sdi_i}), .q_o({sck_s, sdi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_prev_q <= 1'b1;
      sck_prev_q  <= 1'b0;
    end else begin
      conv_prev_q <= conv_s;
      sck_prev_q  <= sck_s;
    end
  end

  assign conv_rise = conv_s & ~conv_prev_q;
  assign sck_rise  = sck_s & ~sck_prev_q;
  assign sck_fall  = ~sck_s & sck_prev_q;
  assign port_en   = ~conv_s && (state != PS_CONV);

  adc_pwr_ctrl #(.CONV_CYC(CONV_CYC), .WAKE_CYC(WAKE_CYC)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .conv_lvl_i (conv_s),
    .conv_rise_i(conv_rise),
    .slp_i      (cfg_o[0]),
    .state_o    (state),
    .start_o    (start),
    .done_o     (done)
  );

  adc_serial_port #(.RES_W(RES_W)) i_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (port_en),
    .sck_rise_i(sck_rise),
    .sck_fall_i(sck_fall),
    .sdi_i     (sdi_s),
    .start_i   (start),
    .done_i    (done),
    .result_i  (sar_data_i),
    .cfg_o     (cfg_o),
    .acq_o     (acq_o),
    .sdo_bit_o (sdo_bit)
  );

  assign sdo_oe_o    = ~conv_s;
  assign sdo_o       = sdo_oe_o & sdo_bit;
  assign pwr_state_o = state;
endmodule

// File: rtl/adc_port_seq_chk.sv
module adc_port_seq_chk
  import adc_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       convst_i,
  input logic       sdo_oe_o,
  input logic [2:0] pwr_state_o,
  input logic [5:0] cfg_o,
  input logic       acq_o
);
  a_r5_hiz_when_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(convst_i, 2) |-> !sdo_oe_o);

  a_r2_conv_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == PS_CONV && $past(pwr_state_o) != PS_CONV) |-> $past(pwr_state_o) == PS_IDLE);

  a_r3_sleep_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == PS_SLEEP && $past(pwr_state_o) == PS_CONV) |-> $past(cfg_o[0]));

  a_r3_nap_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == PS_NAP && $past(pwr_state_o) == PS_CONV) |-> !$past(cfg_o[0]));

  a_r7_cfg_held_in_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == PS_CONV && $past(pwr_state_o) == PS_CONV) |-> $stable(cfg_o));

  a_r8_no_acq_in_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_state_o == PS_CONV |-> !acq_o);

  a_r9_sleep_exits_to_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pwr_state_o) == PS_SLEEP && pwr_state_o != PS_SLEEP) |-> pwr_state_o == PS_WAKE);
endmodule

bind adc_port_seq adc_port_seq_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .convst_i   (convst_i),
  .sdo_oe_o   (sdo_oe_o),
  .pwr_state_o(pwr_state_o),
  .cfg_o      (cfg_o),
  .acq_o      (acq_o)
);

// File: tb/test_adc_port_seq.sv
module test_adc_port_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W      = 12;
  localparam int CC         = 12;
  localparam int WC         = 20;
  localparam int NVEC       = 5;

  // {result, config word for the following frame, convst held high at end}
  localparam logic [18:0] VEC [NVEC] = '{
    {12'hA5C, 6'b100010, 1'b1},
    {12'h3C1, 6'b110111, 1'b0},
    {12'hFFF, 6'b001100, 1'b1},
    {12'h001, 6'b111001, 1'b1},
    {12'h800, 6'b010000, 1'b1}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic convst_i = 1'b0;
  logic sck_i = 1'b0;
  logic sdi_i = 1'b0;
  logic [RES_W-1:0] sar_data_i = '0;
  logic sdo_o, sdo_oe_o, acq_o;
  logic [2:0] pwr_state_o;
  logic [5:0] cfg_o;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_slp = 1'b0;
  logic [5:0] exp_cfg = 6'b100000;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  adc_port_seq #(.RES_W(RES_W), .CONV_CYC(CC), .WAKE_CYC(WC)) i_adc_port_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .convst_i(convst_i), .sck_i(sck_i), .sdi_i(sdi_i),
    .sar_data_i(sar_data_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .pwr_state_o(pwr_state_o), .cfg_o(cfg_o), .acq_o(acq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic sck_pulse(input logic b);
    sdi_i = b;
    cyc(4);
    sck_i = 1'b1;
    cyc(4);
    sck_i = 1'b0;
    cyc(4);
  endtask

  // one conversion; returns with convst low and the block powered
  task automatic run_conv(input logic [RES_W-1:0] data, input logic hold);
    logic [2:0] end_state;
    @(negedge clk_i);
    sar_data_i = data;
    convst_i   = 1'b1;
    cyc(4);
    if (!hold) convst_i = 1'b0;
    cyc(CC - 2);
    chk("R2 conv length", 32'(pwr_state_o), 32'd1);
    if (hold) chk("R5 oe low while high", 32'(sdo_oe_o), 32'd0);
    cyc(1);
    end_state = !hold ? 3'd0 : (exp_slp ? 3'd3 : 3'd2);
    chk(hold ? "R3 power decision" : "R4 stays idle", 32'(pwr_state_o), 32'(end_state));
    chk("R8 acq cleared", 32'(acq_o), 32'd0);
    if (hold) begin
      chk("R5 sdo zero when disabled", 32'(sdo_o), 32'd0);
      sck_pulse(1'b1);  // ignored while convst high
      sck_pulse(1'b0);
      convst_i = 1'b0;
      if (end_state == 3'd3) begin
        cyc(2 + WC);
        chk("R9 wake window", 32'(pwr_state_o), 32'd4);
        cyc(1);
        chk("R9 wake done", 32'(pwr_state_o), 32'd0);
      end else begin
        cyc(3);
        chk("R9 nap exit", 32'(pwr_state_o), 32'd0);
      end
    end
    chk("R5 oe high while low", 32'(sdo_oe_o), 32'd1);
    chk(hold ? "R6 first bit after sck ignored" : "R4 msb at completion", 32'(sdo_o), 32'(data[RES_W-1]));
  endtask

  task automatic run_frame(input logic [RES_W-1:0] data, input logic [5:0] cfg);
    for (int k = 0; k < 14; k++) begin
      sck_pulse(k < 6 ? cfg[5-k] : ~cfg[0]);
      if (k == 4) chk("R7 cfg not yet updated", 32'(cfg_o), 32'(exp_cfg));
      if (k == 5) begin
        chk("R7 cfg latched", 32'(cfg_o), 32'(cfg));
        chk("R8 acq set", 32'(acq_o), 32'd1);
      end
      chk("R6 sdo bit", 32'(sdo_o), (k < 11) ? 32'(data[10-k]) : 32'd0);
    end
    chk("R7 extra edges ignored", 32'(cfg_o), 32'(cfg));
    exp_cfg = cfg;
    exp_slp = cfg[0];
  endtask

  initial begin
    cyc(3);
    chk("R1 state", 32'(pwr_state_o), 32'd0);
    chk("R1 cfg", 32'(cfg_o), 32'h20);
    chk("R1 oe", 32'(sdo_oe_o), 32'd0);
    chk("R1 sdo", 32'(sdo_o), 32'd0);
    chk("R1 acq", 32'(acq_o), 32'd0);
    rst_ni = 1'b1;
    cyc(4);

    for (int i = 0; i < NVEC; i++) begin
      run_conv(VEC[i][18:7], VEC[i][0]);
      run_frame(VEC[i][18:7], VEC[i][6:1]);
    end

    // R2: edges during conversion neither restart nor extend it
    @(negedge clk_i);
    sar_data_i = 12'h5A3;
    convst_i   = 1'b1;
    cyc(3);
    convst_i = 1'b0;
    cyc(3);
    convst_i = 1'b1;
    cyc(3);
    convst_i = 1'b0;
    cyc(CC - 7);
    chk("R2 no restart", 32'(pwr_state_o), 32'd1);
    cyc(1);
    chk("R2 ends on time", 32'(pwr_state_o), 32'd0);
    chk("R4 msb", 32'(sdo_o), 32'd0);
    sck_pulse(1'b0);
    chk("R6 second bit", 32'(sdo_o), 32'd1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule